// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt requests from a set of peripheral request lines plus one non-maskable source, arbitrates among them by fixed priority and raises a single interrupt line towards the processor. When the processor acknowledges, the block returns a vector number for the winning source in the following cycle. It moves that source from pending to in-service. An end-of-interrupt strobe retires the most urgent in-service source.

In-service tracking allows nesting. While a handler runs, only a strictly more urgent request can raise the interrupt line again. Equal or less urgent requests wait until the end-of-interrupt strobe. Request line k can be disabled through a mask bit. A masked line still records its request, and that request competes again once the line is unmasked. The non-maskable source ranks above every line and ignores the mask. A configuration write port loads the mask and an 8-bit vector base in a single cycle.

The control is a three-state machine. `S_IDLE` moves to `S_ASSERT` when a request can win. `S_ASSERT` moves to `S_VECTOR` on an acknowledge, or back to `S_IDLE` when no request can win any more. `S_VECTOR` always returns to `S_IDLE` after one cycle.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, int_o and vec_vld_o are low, no source is pending or in service, every line is unmasked and the vector base is 0x20.
- R2: A request line that is high at a clock edge becomes pending. It stays pending after the line falls, until that source is acknowledged.
- R3: int_o rises one clock after the first edge at which a pending request can win. It remains high while the state machine is in `S_ASSERT` and a winner exists.
- R4: When several requests are pending, the lowest line index wins. The vector is the base plus the line index, modulo 256.
- R5: An acknowledge sampled while int_o is high makes vec_vld_o high for exactly the next cycle and presents vec_o for that cycle. It also moves the winner from pending to in-service. int_o is low during that cycle.
- R6: int_o stays low whenever the best pending request is not strictly more urgent than the most urgent in-service source.
- R7: A request more urgent than every in-service source raises int_o even while a less urgent handler is in service. Its acknowledge adds a second in-service source.
- R8: An end-of-interrupt strobe clears only the most urgent in-service source.
- R9: Mask bit k set to 1 keeps line k out of arbitration while its request still latches as pending. Clearing the bit lets that request compete.
- R10: A pulse on nmi_i becomes pending and outranks line 0. It is never blocked by the mask and always uses vector 2.
- R11: An acknowledge sampled while int_o is low has no effect.
- R12: A configuration write loads the mask and the base at one edge, and both take effect from the next cycle.
- R13: If the winner disappears before it is acknowledged, for example because its line is masked, int_o falls in the next cycle and the machine returns to `S_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NLINES | Peripheral request lines, high = request |
| nmi_i | input | 1 | Non-maskable request |
| ack_i | input | 1 | Acknowledge from the processor |
| eoi_i | input | 1 | End-of-interrupt strobe |
| cfg_we_i | input | 1 | Load mask and base |
| cfg_mask_i | input | NLINES | New mask, bit k = 1 disables line k |
| cfg_base_i | input | 8 | New vector base |
| int_o | output | 1 | Interrupt to the processor |
| vec_vld_o | output | 1 | vec_o is valid this cycle |
| vec_o | output | 8 | Vector of the acknowledged source |

## Verification
Simultaneous pulses on several lines show whether arbitration picks the lowest index and computes the vector from the base. A less urgent request held back behind an in-service handler, followed by a more urgent one, separates correct nesting from plain first-come service. It also shows whether EOI retires the right source. Masked pulses, a line masked between assertion and acknowledge, and a non-maskable pulse under a full mask show whether the mask gates only arbitration. A long random phase then mixes requests, acknowledges, EOIs and configuration writes, and a behavioural model is compared against the outputs every cycle.

// File: rtl/nic_pkg.sv
package nic_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ASSERT = 2'd1,
        S_VECTOR = 2'd2
    } nic_state_e;

    localparam logic [7:0] NMI_VECTOR = 8'd2;
    localparam logic [7:0] BASE_RESET = 8'h20;
endpackage

// File: rtl/nic_first_set.sv
module nic_first_set #(
    parameter int W = 9,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o,
    output logic [W-1:0]  onehot_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = i[IW-1:0];
            end
        end
        onehot_o = found_o ? (W'(1) << idx_o) : '0;
    end
endmodule

// File: rtl/nic_src_regs.sv
module nic_src_regs
    import nic_pkg::*;
#(
    parameter int NLINES = 8,
    localparam int NSRC = NLINES + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] req_i,
    input  logic              nmi_i,
    input  logic              cfg_we_i,
    input  logic [NLINES-1:0] cfg_mask_i,
    input  logic [7:0]        cfg_base_i,
    input  logic              take_i,
    input  logic [NSRC-1:0]   take_oh_i,
    output logic [NSRC-1:0]   cand_o,
    output logic              nmi_pend_o,
    output logic [7:0]        base_o
);
    logic [NLINES-1:0] pend_q;
    logic [NLINES-1:0] mask_q;
    logic              nmi_q;
    logic [7:0]        base_q;
    logic [NSRC-1:0]   clr;

    assign clr = take_i ? take_oh_i : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            nmi_q  <= 1'b0;
            mask_q <= '0;
            base_q <= BASE_RESET;
        end else begin
            pend_q <= (pend_q | req_i) & ~clr[NSRC-1:1];
            nmi_q  <= (nmi_q | nmi_i) & ~clr[0];
            if (cfg_we_i) begin
                mask_q <= cfg_mask_i;
                base_q <= cfg_base_i;
            end
        end
    end

    assign cand_o     = {pend_q & ~mask_q, nmi_q};
    assign nmi_pend_o = nmi_q;
    assign base_o     = base_q;
endmodule

// File: rtl/nic_inservice.sv
module nic_inservice #(
    parameter int NSRC = 9,
    localparam int IW = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            eoi_i,
    input  logic            take_i,
    input  logic [NSRC-1:0] take_oh_i,
    output logic [NSRC-1:0] isr_o,
    output logic            top_found_o,
    output logic [IW-1:0]   top_idx_o
);
    logic [NSRC-1:0] isr_q;
    logic [NSRC-1:0] top_oh;

    nic_first_set #(.W(NSRC)) u_top (
        .vec_i   (isr_q),
        .found_o (top_found_o),
        .idx_o   (top_idx_o),
        .onehot_o(top_oh)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= '0;
        end else begin
            isr_q <= (isr_q & ~(eoi_i ? top_oh : '0)) | (take_i ? take_oh_i : '0);
        end
    end

    assign isr_o = isr_q;
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int NLINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] req_i,
    input  logic              nmi_i,
    input  logic              ack_i,
    input  logic              eoi_i,
    input  logic              cfg_we_i,
    input  logic [NLINES-1:0] cfg_mask_i,
    input  logic [7:0]        cfg_base_i,
    output logic              int_o,
    output logic              vec_vld_o,
    output logic [7:0]        vec_o
);
    localparam int NSRC = NLINES + 1;
    localparam int IW   = $clog2(NSRC);

    nic_state_e      state_q, state_d;
    logic [NSRC-1:0] cand, best_oh, isr_q;
    logic [IW-1:0]   best_idx, top_idx;
    logic            best_found, top_found, fire, take, nmi_pend_w;
    logic [7:0]      base, vec_q;

    nic_src_regs #(.NLINES(NLINES)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .nmi_i     (nmi_i),
        .cfg_we_i  (cfg_we_i),
        .cfg_mask_i(cfg_mask_i),
        .cfg_base_i(cfg_base_i),
        .take_i    (take),
        .take_oh_i (best_oh),
        .cand_o    (cand),
        .nmi_pend_o(nmi_pend_w),
        .base_o    (base)
    );

    nic_first_set #(.W(NSRC)) u_best (
        .vec_i   (cand),
        .found_o (best_found),
        .idx_o   (best_idx),
        .onehot_o(best_oh)
    );

    nic_inservice #(.NSRC(NSRC)) u_isr (
        .clk        (clk),
        .rst_n      (rst_n),
        .eoi_i      (eoi_i),
        .take_i     (take),
        .take_oh_i  (best_oh),
        .isr_o      (isr_q),
        .top_found_o(top_found),
        .top_idx_o  (top_idx)
    );

    assign fire = best_found && (!top_found || (best_idx < top_idx));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                vec_q <= (best_idx == '0) ? NMI_VECTOR
                                          : base + 8'(best_idx) - 8'd1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (fire) state_d = S_ASSERT;
            S_ASSERT: begin
                if (!fire)      state_d = S_IDLE;
                else if (ack_i) state_d = S_VECTOR;
            end
            S_VECTOR: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_comb begin
        int_o     = (state_q == S_ASSERT) && fire;
        take      = int_o && ack_i;
        vec_vld_o = (state_q == S_VECTOR);
        vec_o     = vec_q;
    end
endmodule

// File: rtl/nic_chk.sv
module nic_chk #(
    parameter int NSRC = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic            int_o,
    input logic            ack_i,
    input logic            eoi_i,
    input logic            vec_vld_o,
    input logic [7:0]      vec_o,
    input logic            nmi_pend,
    input logic [NSRC-1:0] isr
);
    a_r5_vld_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (int_o && ack_i) |=> vec_vld_o);
    a_r5_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld_o |=> !vec_vld_o);
    a_r5_no_int_in_vld: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld_o |-> !int_o);
    a_r11_vld_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!(int_o && ack_i)) |=> !vec_vld_o);
    a_r10_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (int_o && ack_i && nmi_pend) |=> (vec_o == 8'd2));
    a_r7_isr_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (int_o && ack_i && !eoi_i) |=> ($countones(isr) == $past($countones(isr)) + 1));
    a_r8_eoi_one: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !(int_o && ack_i) && (isr != '0)) |=> ($countones(isr) == $past($countones(isr)) - 1));
    a_r6_nmi_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        isr[0] |-> !int_o);
endmodule

bind nest_irq_ctrl nic_chk #(.NSRC(NSRC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .int_o    (int_o),
    .ack_i    (ack_i),
    .eoi_i    (eoi_i),
    .vec_vld_o(vec_vld_o),
    .vec_o    (vec_o),
    .nmi_pend (nmi_pend_w),
    .isr      (isr_q)
);

// File: tb/sim_nest_irq_ctrl.sv
`timescale 1ns/1ps
module sim_nest_irq_ctrl;
    localparam int NL = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] req_i = '0;
    logic          nmi_i = 1'b0, ack_i = 1'b0, eoi_i = 1'b0, cfg_we_i = 1'b0;
    logic [NL-1:0] cfg_mask_i = '0;
    logic [7:0]    cfg_base_i = '0;
    logic          int_o, vec_vld_o;
    logic [7:0]    vec_o;

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    nest_irq_ctrl #(.NLINES(NL)) u0 (.*);

    // behavioural reference model, index 0 = NMI, index k+1 = line k
    bit mpend[NL+1];
    bit misr[NL+1];
    bit mmask[NL];
    int mbase, mst, mvec;

    function automatic int m_best();
        for (int i = 0; i <= NL; i++)
            if (mpend[i] && (i == 0 || !mmask[i-1])) return i;
        return -1;
    endfunction

    function automatic int m_top();
        for (int i = 0; i <= NL; i++) if (misr[i]) return i;
        return -1;
    endfunction

    function automatic bit m_fire();
        int b, t;
        b = m_best();
        t = m_top();
        return (b >= 0) && (t < 0 || b < t);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i <= NL; i++) begin mpend[i] = 0; misr[i] = 0; end
            for (int i = 0; i < NL; i++) mmask[i] = 0;
            mbase = 32; mst = 0; mvec = 0;
        end else begin
            int b, t;
            bit f, tk;
            b = m_best(); t = m_top(); f = m_fire();
            tk = (mst == 1) && f && ack_i;
            if (tk) mvec = (b == 0) ? 2 : ((mbase + b - 1) % 256);
            if (eoi_i && t >= 0) misr[t] = 0;
            if (tk) misr[b] = 1;
            for (int i = 0; i < NL; i++) if (req_i[i]) mpend[i+1] = 1;
            if (nmi_i) mpend[0] = 1;
            if (tk) mpend[b] = 0;
            if (cfg_we_i) begin
                for (int i = 0; i < NL; i++) mmask[i] = cfg_mask_i[i];
                mbase = cfg_base_i;
            end
            case (mst)
                0: if (f) mst = 1;
                1: if (tk) mst = 2; else if (!f) mst = 0;
                default: mst = 0;
            endcase
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit ei, ev;
            ei = (mst == 1) && m_fire();
            ev = (mst == 2);
            n_vec++;
            if (int_o !== ei || vec_vld_o !== ev || (ev && vec_o !== mvec[7:0])) begin
                n_bad++;
                $display("FAIL R3/R5/R6 model compare: int=%0b vld=%0b vec=%0h expected int=%0b vld=%0b vec=%0h",
                         int_o, vec_vld_o, vec_o, ei, ev, mvec[7:0]);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_req(input logic [NL-1:0] r);
        req_i = r; @(negedge clk); req_i = '0;
    endtask

    task automatic wait_int(input string tag);
        int k = 0;
        while (!int_o && k < 20) begin @(negedge clk); k++; end
        chk(int_o === 1'b1, tag, int_o, 1);
    endtask

    task automatic do_ack(input int exp, input string tag);
        ack_i = 1; @(negedge clk); ack_i = 0;
        chk(vec_vld_o === 1'b1 && vec_o === exp[7:0], tag, vec_o, exp);
    endtask

    task automatic do_eoi();
        eoi_i = 1; @(negedge clk); eoi_i = 0;
    endtask

    task automatic cfg(input logic [NL-1:0] m, input logic [7:0] b);
        cfg_we_i = 1; cfg_mask_i = m; cfg_base_i = b; @(negedge clk); cfg_we_i = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1;
        @(negedge clk);
        chk(int_o === 0 && vec_vld_o === 0, "R1 reset outputs", int_o, 0);
        // R11: acknowledge while int_o is low
        ack_i = 1; @(negedge clk); ack_i = 0;
        chk(vec_vld_o === 0, "R11 stray ack", vec_vld_o, 0);
        // R2 R4: lines 5 and 2 together, one-cycle pulse
        pulse_req(8'b0010_0100);
        @(negedge clk);
        chk(int_o === 1, "R3 int timing", int_o, 1);
        do_ack(32'h22, "R4 lowest index wins");
        idle(4);
        chk(int_o === 0, "R6 less urgent held back", int_o, 0);
        // R7: line 0 nests over line 2
        pulse_req(8'b0000_0001);
        wait_int("R7 nest raises int");
        do_ack(32'h20, "R7 nested vector");
        do_eoi();
        idle(3);
        chk(int_o === 0, "R8 eoi cleared only line 0", int_o, 0);
        do_eoi();
        wait_int("R2 line 5 still pending");
        do_ack(32'h25, "R2 R4 line 5 vector");
        do_eoi();
        // R9 R12: mask line 3, new base
        cfg(8'b0000_1000, 8'h40);
        pulse_req(8'b0000_1000);
        idle(4);
        chk(int_o === 0, "R9 masked line silent", int_o, 0);
        cfg(8'h00, 8'h40);
        wait_int("R9 unmasked competes");
        do_ack(32'h43, "R12 new base used");
        do_eoi();
        // R10: NMI under full mask
        cfg(8'hFF, 8'h40);
        nmi_i = 1; @(negedge clk); nmi_i = 0;
        wait_int("R10 nmi ignores mask");
        do_ack(2, "R10 nmi vector");
        cfg(8'h00, 8'h40);
        pulse_req(8'b0000_0001);
        idle(4);
        chk(int_o === 0, "R6 line 0 below nmi in service", int_o, 0);
        do_eoi();
        wait_int("R8 release after nmi eoi");
        do_ack(32'h40, "R4 line 0 vector");
        do_eoi();
        // R13: winner masked before acknowledge
        pulse_req(8'b0100_0000);
        wait_int("R13 raised");
        cfg(8'b0100_0000, 8'h40);
        chk(int_o === 0, "R13 withdrawn", int_o, 0);
        cfg(8'h00, 8'h40);
        wait_int("R13 re-raised");
        do_ack(32'h46, "R13 vector");
        do_eoi();
        // random mix, model comparison every cycle
        for (int c = 0; c < 4000; c++) begin
            req_i      = ($urandom % 6 == 0) ? NL'(1) << ($urandom % NL) : '0;
            nmi_i      = ($urandom % 97 == 0);
            ack_i      = int_o ? ($urandom % 2 == 0) : ($urandom % 20 == 0);
            eoi_i      = ($urandom % 9 == 0);
            cfg_we_i   = ($urandom % 50 == 0);
            cfg_mask_i = ($urandom % 3 == 0) ? NL'($urandom) : '0;
            cfg_base_i = 8'($urandom);
            @(negedge clk);
        end
        req_i = '0; nmi_i = 0; ack_i = 0; eoi_i = 0; cfg_we_i = 0;
        idle(2);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule